// File: doc/BRIEF.md
# Per-Core Interval Tick Timer

This block is a single local tick timer of the kind that sits beside each processor core in a timer bank. A first-stage prescaler divides the input clock by a programmable amount; each prescaler tick steps a second-stage interrupt counter downwards. When the interrupt counter runs out, the block latches an interrupt status bit that, when enabled, drives the interrupt output. In interval mode the counter reloads from its buffer and the timer keeps firing until software clears the start bits. Outside interval mode it fires once and then waits.

Software reaches the block through a 32-bit register window addressed by byte offset. Writes to the prescaler buffer, the interrupt count buffer and the control register each raise a sticky acknowledge flag that software clears by writing 1. Reads are combinational on the current address. One instance serves one 256-byte window; picking the window for each core is left to the surrounding logic.

Top module: `core_tick_timer`

## Requirements
- R1: After a synchronous active-low reset every register reads zero, both start bits are off and `irq` is low; unmapped offsets read zero.
- R2: The prescaler limit register at offset 0x00 reads back as written; with value N and control bit 0 (run) set, the interrupt counter steps once every N+1 clocks, the first step N+1 clocks after run is set.
- R3: A write to offset 0x08 with bit 31 set stores bits 30:0 as the reload value (read back at 0x08 with bit 31 zero) and loads them into the interrupt counter at once; a write with bit 31 clear changes neither.
- R4: When the prescaler steps while the interrupt counter holds 1 (or 0) and control bits 0 and 1 are both set, status bit 0 at offset 0x30 is set on that clock; a reload value K therefore fires after K steps.
- R5: With control bit 2 (interval) set, the counter reloads from the reload value at each expiry and the timer fires every K·(N+1) clocks.
- R6: With control bit 2 clear, the timer fires once and does not fire again until run is cleared or the counter is reloaded through offset 0x08.
- R7: With control bit 1 (interrupt start) clear the interrupt counter holds its value and no expiry occurs, while the prescaler keeps running.
- R8: While control bit 0 is clear the prescaler is held at zero and the interrupt counter at the reload value, so setting run again restarts a full period.
- R9: Writing 1 to bit 0 of offset 0x30 clears the status bit; an expiry in the same clock wins over the clear.
- R10: `irq` is high exactly when the status bit and bit 0 of the enable register at offset 0x34 are both set.
- R11: The acknowledge register at offset 0x40 sets bit 0 on a write to 0x00, bit 1 on a write to 0x08 and bit 3 on a write to 0x20; each bit clears when 1 is written to it at 0x40, and bit 2 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | 8 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions take for granted that reset is held low from time zero for at least one clock, that each write lasts a single clock at an exact word offset, and that the bus inputs are never unknown while reset is released. The stimulus respects this by driving every input from one task on the falling edge, holding `bus_wr` for exactly one step per write and using only the mapped offsets plus one unmapped probe. Prescaler limits and reload values are kept small so each period, one-shot hold-off and restart can be observed many times within the run, and limits are changed mid-count to exercise the prescaler wrap when its count already exceeds the new limit.

// File: rtl/ctt_pkg.sv
// Shared constants for the per-core tick timer: register offsets,
// control bit positions and acknowledge bit positions.
// Assumes a byte-addressed window with word-aligned registers.
package ctt_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;
    localparam int ACK_W  = 4;

    // Register offsets within the window
    localparam logic [ADDR_W-1:0] OFS_PRE  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_RLD  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CTL  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_STS  = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_ENA  = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_ACK  = 8'h40;

    // Control register bits
    localparam int CTL_RUN = 0;
    localparam int CTL_INT = 1;
    localparam int CTL_IVL = 2;
    localparam int CTL_W   = 3;

    // Acknowledge register bits
    localparam int ACK_PRE = 0;
    localparam int ACK_RLD = 1;
    localparam int ACK_CTL = 3;

    // Reload-request flag in a reload buffer write
    localparam int LOAD_BIT = 31;

    typedef struct packed {
        logic interval;
        logic int_run;
        logic run;
    } ctl_t;
endpackage

// File: rtl/ctt_prescaler.sv
// First-stage divider. Counts clocks while run is high and emits a one-clock
// step when the count reaches or passes the limit, then restarts at zero.
// Assumes limit may change at any time; a count already past a lowered limit
// steps on the next clock. Held at zero while run is low.
module ctt_prescaler #(
    parameter int PRE_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] limit,
    output logic             step
);
    logic [PRE_W-1:0] count;

    // Step when the count has reached the programmed limit
    always_comb step = run && (count >= limit);

    // Advance, wrap on step, or hold at zero when stopped
    always_ff @(posedge clk) begin
        if (!rst_n)        count <= '0;
        else if (!run)     count <= '0;
        else if (step)     count <= '0;
        else               count <= count + 1'b1;
    end

    // R2: after a step the count restarts from zero
    assert_step_wraps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (count == '0));

    // R2: without a step a running count advances by exactly one
    assert_count_advances_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !step) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/ctt_intcnt.sv
// Second-stage interrupt counter. Steps down on each prescaler step while both
// start bits are set, signals expiry when a step meets a count of one or zero,
// and then reloads (interval mode) or parks at zero until rearmed (one-shot).
// Assumes load requests carry the value to load; they override everything else.
module ctt_intcnt #(
    parameter int CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             int_run,
    input  logic             interval,
    input  logic             step,
    input  logic             load_req,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count;
    logic             spent;
    logic             active_step;

    // A step that may move the counter this clock
    always_comb active_step = run && int_run && step && !spent && !load_req;

    // Expiry when the last step lands on a count of one or below
    always_comb expire = active_step && (count <= ONE);

    // Next count: load, park at reload while stopped, reload/park on expiry, decrement
    always_ff @(posedge clk) begin
        if (!rst_n)            count <= '0;
        else if (load_req)     count <= load_val;
        else if (!run)         count <= reload_val;
        else if (expire)       count <= interval ? reload_val : '0;
        else if (active_step)  count <= count - ONE;
    end

    // One-shot latch: set on a non-interval expiry, rearmed by stop or load
    always_ff @(posedge clk) begin
        if (!rst_n)                    spent <= 1'b0;
        else if (load_req || !run)     spent <= 1'b0;
        else if (expire && !interval)  spent <= 1'b1;
    end

    // R6: a one-shot expiry leaves the counter parked
    assert_oneshot_parks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !interval) |=> (spent && count == '0));

    // R6: once parked no further expiry until rearmed
    assert_oneshot_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (spent && run && !load_req) |-> !expire);

    // R5: interval expiry reloads from the buffer
    assert_interval_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && interval) |=> (count == $past(reload_val)));

    // R8: a stopped timer sits at the reload value
    assert_stopped_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_req) |=> (count == $past(reload_val)));

    // R7: interrupt start low freezes the counter
    assert_int_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !int_run && !load_req) |=> (count == $past(count)));
endmodule

// File: rtl/ctt_regs.sv
// Register window of the tick timer: prescaler limit, reload buffer, control,
// sticky status, enable and sticky write acknowledges, plus combinational
// read-back. Assumes single-clock write strobes at exact word offsets.
module ctt_regs
    import ctt_pkg::*;
#(
    parameter int PRE_W = 32,
    parameter int CNT_W = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              expire,
    output logic [PRE_W-1:0]  pre_limit,
    output logic [CNT_W-1:0]  reload_val,
    output logic              load_req,
    output logic [CNT_W-1:0]  load_val,
    output ctl_t              ctl,
    output logic              irq
);
    localparam int PRE_PAD = BUS_W - PRE_W;
    localparam int CNT_PAD = BUS_W - CNT_W;

    logic             sel_pre, sel_rld, sel_ctl, sel_sts, sel_ena, sel_ack;
    logic             status;
    logic             enable;
    logic [ACK_W-1:0] ack;
    logic [ACK_W-1:0] ack_set;

    // Write decode per register
    always_comb begin
        sel_pre = bus_wr && (bus_addr == OFS_PRE);
        sel_rld = bus_wr && (bus_addr == OFS_RLD);
        sel_ctl = bus_wr && (bus_addr == OFS_CTL);
        sel_sts = bus_wr && (bus_addr == OFS_STS);
        sel_ena = bus_wr && (bus_addr == OFS_ENA);
        sel_ack = bus_wr && (bus_addr == OFS_ACK);
    end

    // Reload request only when the flag bit accompanies the write
    always_comb begin
        load_req = sel_rld && bus_wdata[LOAD_BIT];
        load_val = bus_wdata[CNT_W-1:0];
    end

    // Prescaler limit register
    always_ff @(posedge clk) begin
        if (!rst_n)       pre_limit <= '0;
        else if (sel_pre) pre_limit <= bus_wdata[PRE_W-1:0];
    end

    // Reload buffer, updated only on a flagged write
    always_ff @(posedge clk) begin
        if (!rst_n)        reload_val <= '0;
        else if (load_req) reload_val <= load_val;
    end

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n)       ctl <= '0;
        else if (sel_ctl) ctl <= ctl_t'(bus_wdata[CTL_W-1:0]);
    end

    // Sticky status: expiry sets, write-one clears, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)                      status <= 1'b0;
        else if (expire)                 status <= 1'b1;
        else if (sel_sts && bus_wdata[0]) status <= 1'b0;
    end

    // Interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n)       enable <= 1'b0;
        else if (sel_ena) enable <= bus_wdata[0];
    end

    // Which acknowledge bits a write raises this clock
    always_comb begin
        ack_set          = '0;
        ack_set[ACK_PRE] = sel_pre;
        ack_set[ACK_RLD] = sel_rld;
        ack_set[ACK_CTL] = sel_ctl;
    end

    // One sticky flag per acknowledge bit, cleared by write-one
    for (genvar i = 0; i < ACK_W; i++) begin : g_ack
        always_ff @(posedge clk) begin
            if (!rst_n)                       ack[i] <= 1'b0;
            else if (ack_set[i])              ack[i] <= 1'b1;
            else if (sel_ack && bus_wdata[i]) ack[i] <= 1'b0;
        end
    end

    // Combinational read-back by offset
    always_comb begin
        case (bus_addr)
            OFS_PRE: bus_rdata = {{PRE_PAD{1'b0}}, pre_limit};
            OFS_RLD: bus_rdata = {{CNT_PAD{1'b0}}, reload_val};
            OFS_CTL: bus_rdata = {{(BUS_W-CTL_W){1'b0}}, ctl};
            OFS_STS: bus_rdata = {{(BUS_W-1){1'b0}}, status};
            OFS_ENA: bus_rdata = {{(BUS_W-1){1'b0}}, enable};
            OFS_ACK: bus_rdata = {{(BUS_W-ACK_W){1'b0}}, ack};
            default: bus_rdata = '0;
        endcase
    end

    // Interrupt output gated by enable
    always_comb irq = status && enable;

    // R4: an expiry latches the status bit
    assert_expiry_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> status);

    // R9: write-one clears status when no expiry competes
    assert_status_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_sts && bus_wdata[0] && !expire) |=> !status);

    // R11: a control write raises its acknowledge bit
    assert_ctl_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ctl |=> ack[ACK_CTL]);

    // R3: an unflagged reload write leaves the buffer alone
    assert_rld_unflagged_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rld && !bus_wdata[LOAD_BIT]) |=> $stable(reload_val));

    // R10: no interrupt without enable
    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !irq);
endmodule

// File: rtl/core_tick_timer.sv
// Top of one per-core tick timer: register window, prescaler and interrupt
// counter. Assumes one instance per 256-byte window and that reset is held
// low for at least one clock at power-up.
module core_tick_timer
    import ctt_pkg::*;
#(
    parameter int PRE_W = 32,
    parameter int CNT_W = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    logic [PRE_W-1:0] pre_limit;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] load_val;
    logic             load_req;
    logic             step;
    logic             expire;
    ctl_t             ctl;

    ctt_regs #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .expire     (expire),
        .pre_limit  (pre_limit),
        .reload_val (reload_val),
        .load_req   (load_req),
        .load_val   (load_val),
        .ctl        (ctl),
        .irq        (irq)
    );

    ctt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctl.run),
        .limit (pre_limit),
        .step  (step)
    );

    ctt_intcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctl.run),
        .int_run    (ctl.int_run),
        .interval   (ctl.interval),
        .step       (step),
        .load_req   (load_req),
        .load_val   (load_val),
        .reload_val (reload_val),
        .expire     (expire)
    );

    // R7: no expiry can occur with interrupt start low
    assert_no_expiry_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.int_run |-> !expire);
endmodule

// File: tb/core_tick_timer_tb.sv
module core_tick_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    core_tick_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    int    cycles = 0;
    string cur_req = "R1";
    logic  rst_next = 1'b0;

    // Behavioural reference state
    bit [31:0] m_pre, m_pc;
    bit [30:0] m_rld, m_ic;
    bit [2:0]  m_ctl;
    bit        m_sts, m_ena, m_spent;
    bit [3:0]  m_ack;

    function automatic bit [31:0] m_read(input bit [7:0] a);
        case (a)
            8'h00:   return m_pre;
            8'h08:   return {1'b0, m_rld};
            8'h20:   return {29'd0, m_ctl};
            8'h30:   return {31'd0, m_sts};
            8'h34:   return {31'd0, m_ena};
            8'h40:   return {28'd0, m_ack};
            default: return 32'd0;
        endcase
    endfunction

    // Next state seen at the coming rising edge
    task automatic m_next(input bit rn, input bit w, input bit [7:0] a, input bit [31:0] d);
        bit run, irun, ivl, stp, upd, mv, exp;
        if (!rn) begin
            m_pre = 0; m_pc = 0; m_rld = 0; m_ic = 0; m_ctl = 0;
            m_sts = 0; m_ena = 0; m_spent = 0; m_ack = 0;
            return;
        end
        run = m_ctl[0]; irun = m_ctl[1]; ivl = m_ctl[2];
        stp = run && (m_pc >= m_pre);
        upd = w && a == 8'h08 && d[31];
        mv  = run && irun && stp && !m_spent && !upd;
        exp = mv && (m_ic <= 1);
        if (upd)       m_ic = d[30:0];
        else if (!run) m_ic = m_rld;
        else if (exp)  m_ic = ivl ? m_rld : 31'd0;
        else if (mv)   m_ic = m_ic - 1;
        if (upd || !run)      m_spent = 0;
        else if (exp && !ivl) m_spent = 1;
        m_pc = (!run || stp) ? 32'd0 : m_pc + 1;
        if (exp) m_sts = 1;
        else if (w && a == 8'h30 && d[0]) m_sts = 0;
        if (w && a == 8'h40) m_ack = m_ack & ~d[3:0];
        if (w && a == 8'h00) begin m_pre = d; m_ack[0] = 1; end
        if (w && a == 8'h08) begin m_ack[1] = 1; if (d[31]) m_rld = d[30:0]; end
        if (w && a == 8'h20) begin m_ctl = d[2:0]; m_ack[3] = 1; end
        if (w && a == 8'h34) m_ena = d[0];
    endtask

    task automatic compare();
        bit [31:0] er;
        bit        ei;
        er = m_read(bus_addr);
        ei = m_sts && m_ena;
        checks++;
        if (irq !== ei) begin
            fails++;
            $display("FAIL %s irq got %0b exp %0b at cycle %0d", cur_req, irq, ei, cycles);
        end
        checks++;
        if (bus_rdata !== er) begin
            fails++;
            $display("FAIL %s rdata[%02h] got %08h exp %08h at cycle %0d",
                     cur_req, bus_addr, bus_rdata, er, cycles);
        end
    endtask

    // One clock: compare on the falling edge, then drive and advance the model
    task automatic step(input bit w, input bit [7:0] a, input bit [31:0] d);
        @(negedge clk);
        compare();
        rst_n = rst_next; bus_wr = w; bus_addr = a; bus_wdata = d;
        m_next(rst_next, w, a, d);
    endtask

    task automatic idle(input int n, input bit [7:0] a);
        for (int i = 0; i < n; i++) step(1'b0, a, 32'd0);
    endtask

    task automatic wr(input bit [7:0] a, input bit [31:0] d);
        step(1'b1, a, d);
    endtask

    // Wait for an interrupt, read it and clear it, several times
    task automatic service(input int rounds, input int gap);
        for (int r = 0; r < rounds; r++) begin
            idle(gap, 8'h30);
            wr(8'h30, 32'd1);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state on every register and an unmapped offset
        cur_req = "R1";
        rst_next = 1'b0;
        idle(3, 8'h00);
        rst_next = 1'b1;
        idle(1, 8'h00);
        idle(1, 8'h08); idle(1, 8'h20); idle(1, 8'h30);
        idle(1, 8'h34); idle(1, 8'h40); idle(1, 8'h44);

        // R2 and R11: prescaler limit write, read-back and acknowledge
        cur_req = "R2";
        wr(8'h00, 32'd2);
        idle(1, 8'h00);
        cur_req = "R11";
        idle(1, 8'h40);

        // R3: flagged reload write
        cur_req = "R3";
        wr(8'h08, 32'h8000_0003);
        idle(1, 8'h08);

        // R4 and R6: one-shot, fires after 3 x 3 clocks, then silent
        cur_req = "R10";
        wr(8'h34, 32'd1);
        cur_req = "R4";
        wr(8'h20, 32'd3);
        idle(14, 8'h30);
        cur_req = "R9";
        wr(8'h30, 32'd1);
        cur_req = "R6";
        idle(25, 8'h30);

        // R6: rearm by a flagged load while running
        wr(8'h08, 32'h8000_0002);
        idle(12, 8'h30);
        wr(8'h30, 32'd1);

        // R8: stop, then interval mode with limit 1 and reload 2
        cur_req = "R8";
        wr(8'h20, 32'd0);
        idle(3, 8'h20);
        wr(8'h00, 32'd1);
        cur_req = "R5";
        wr(8'h20, 32'd7);
        service(4, 5);
        idle(9, 8'h30);

        // R9: clear collides with expiry at various phases
        cur_req = "R9";
        for (int k = 0; k < 6; k++) begin
            wr(8'h30, 32'd1);
            idle(k % 3, 8'h30);
        end

        // R3: unflagged write leaves the buffer and counter alone
        cur_req = "R3";
        wr(8'h08, 32'h0000_0005);
        idle(12, 8'h08);

        // R2: lower the limit mid-count, then a larger limit
        cur_req = "R2";
        wr(8'h00, 32'd5);
        idle(3, 8'h30);
        wr(8'h00, 32'd0);
        service(3, 4);
        wr(8'h00, 32'd4);
        service(2, 12);

        // R7: interrupt start off, prescaler running
        cur_req = "R7";
        wr(8'h30, 32'd1);
        wr(8'h20, 32'd5);
        idle(30, 8'h30);
        wr(8'h20, 32'd7);
        idle(12, 8'h30);

        // R10: status set with enable toggled
        cur_req = "R10";
        wr(8'h34, 32'd0);
        idle(8, 8'h34);
        wr(8'h34, 32'd1);
        idle(3, 8'h30);

        // R8: stop mid-period and restart a full period
        cur_req = "R8";
        wr(8'h30, 32'd1);
        idle(4, 8'h30);
        wr(8'h20, 32'd0);
        idle(5, 8'h30);
        wr(8'h20, 32'd3);
        idle(14, 8'h30);
        wr(8'h30, 32'd1);

        // R4: zero reload behaves as one, limit zero steps every clock
        cur_req = "R4";
        wr(8'h00, 32'd0);
        wr(8'h08, 32'h8000_0000);
        wr(8'h20, 32'd7);
        service(3, 2);
        wr(8'h20, 32'd0);

        // R11: acknowledge clearing, one bit at a time, bit 2 stays zero
        cur_req = "R11";
        idle(1, 8'h40);
        wr(8'h40, 32'd1);
        idle(1, 8'h40);
        wr(8'h40, 32'd4);
        idle(1, 8'h40);
        wr(8'h40, 32'hF);
        idle(2, 8'h40);
        wr(8'h08, 32'h0000_0001);
        idle(2, 8'h40);

        // R1: reset again mid-activity
        cur_req = "R1";
        wr(8'h20, 32'd7);
        idle(4, 8'h30);
        rst_next = 1'b0;
        idle(2, 8'h20);
        rst_next = 1'b1;
        idle(3, 8'h40);
        idle(1, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule